// File: doc/BRIEF.md
# Complex Conjugate Dot Product Unit

This block reduces two equal-length vectors of signed fixed-point complex numbers to one complex scalar. For each lane it negates the imaginary part of the first operand, multiplies it by the matching lane of the second operand, and then adds the lane products together. Parameters set the element width, the lane count, the result width, how many low product bits are dropped, the adder arrangement, and the overflow policy. The adders can form a serial chain or a balanced binary tree. Overflow either wraps or clamps.

A valid strobe travels with the operands. Optional register stages can sit before the multipliers and after the adders. With both stage counts at zero the block is purely combinational. A real operand is fed by tying its imaginary lanes to zero.

Top module: `cdot_unit`

## Requirements
- R1: The result real part is the sum over lanes of (ar*br + ai*bi). The result imaginary part is the sum over lanes of (ar*bi - ai*br). In other words, the first operand is conjugated.
- R2: The lane count LEN is a parameter, and LEN = 1 (scalar operands) gives the single conjugate product.
- R3: When every imaginary input lane of both operands is zero, the imaginary result is zero.
- R4: With SATURATE = 0, a value outside the RES_W-bit signed range keeps only its low RES_W bits in two's complement. For example, a 16-bit lane product of 32768 becomes -32768.
- R5: With SATURATE = 1, an out-of-range value clamps to -2^(RES_W-1) or 2^(RES_W-1)-1. For RES_W = 16 these are -32768 and 32767.
- R6: With SATURATE = 1, clamping is applied to every lane product and to every partial sum, not only to the final output. In a tree, two partial sums of +40000 and -40000 clamp to 32767 and -32768 and give -1.
- R7: TREE = 0 (chain) and TREE = 1 (tree) give identical results whenever SATURATE = 0.
- R8: out_valid rises exactly IN_STAGES + OUT_STAGES cycles after in_valid. A new operand pair is accepted on every cycle. A cycle with in_valid low yields out_valid low at the same latency.
- R9: Each lane product is narrowed by an arithmetic right shift of DROP_LSB bits, which rounds toward negative infinity. With DROP_LSB = 1, the value -3 gives -2 and 9 gives 4.
- R10: A synchronous active-high rst clears every pipeline register. While reset is asserted and afterwards, out_valid, y_re and y_im stay zero until new valid data has crossed the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is valid this cycle |
| a_re | input | LEN*ELEM_W | First operand real lanes, lane i at bits [i*ELEM_W +: ELEM_W] |
| a_im | input | LEN*ELEM_W | First operand imaginary lanes (conjugated) |
| b_re | input | LEN*ELEM_W | Second operand real lanes |
| b_im | input | LEN*ELEM_W | Second operand imaginary lanes |
| out_valid | output | 1 | Result valid |
| y_re | output | RES_W | Signed real part of the result |
| y_im | output | RES_W | Signed imaginary part of the result |

## Verification
The operand patterns include purely real vectors and a single complex lane, which expose a missing or misplaced conjugation sign. An all -128 vector overflows each lane product, so wrap mode and saturate mode give different results. A vector whose tree partial sums overflow in opposite directions yields -1 when saturating and 0 when wrapping, which separates per-stage clamping from clamping only at the output. A chain instance and a tree instance receive identical data to show that their results agree. A one-lane instance with one dropped bit checks floor narrowing on odd negative products. The pipelined instance is fed every cycle and then with gaps, followed by a reset in mid-stream.

// File: rtl/cdot_pkg.sv
package cdot_pkg;

  typedef logic signed [63:0] wide_t;

  // Bring a wide value into a w-bit signed range: clamp or keep low bits.
  function automatic wide_t fit(input wide_t v, input int w, input bit sat);
    wide_t hi, lo, r;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (sat) begin
      if (v > hi)      r = hi;
      else if (v < lo) r = lo;
      else             r = v;
    end else begin
      r = v <<< (64 - w);
      r = r >>> (64 - w);
    end
    return r;
  endfunction

  // Conjugate product, real part: ar*br + ai*bi
  function automatic wide_t conj_re(input wide_t ar, input wide_t ai,
                                    input wide_t br, input wide_t bi);
    return ar * br + ai * bi;
  endfunction

  // Conjugate product, imaginary part: ar*bi - ai*br
  function automatic wide_t conj_im(input wide_t ar, input wide_t ai,
                                    input wide_t br, input wide_t bi);
    return ar * bi - ai * br;
  endfunction

endpackage

// File: rtl/cdot_pipe.sv
module cdot_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         vin,
  output logic [W-1:0] dout,
  output logic         vout
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
      assign vout = vin;
    end else begin : g_regs
      localparam int AW = $clog2(DEPTH + 1);
      logic [W-1:0]     d_q [DEPTH];
      logic [DEPTH-1:0] v_q;
      logic [AW-1:0]    age;   // cycles since reset, saturating at DEPTH

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < DEPTH; k++) d_q[k] <= '0;
          v_q <= '0;
          age <= '0;
        end else begin
          d_q[0] <= din;
          v_q[0] <= vin;
          for (int k = 1; k < DEPTH; k++) begin
            d_q[k] <= d_q[k-1];
            v_q[k] <= v_q[k-1];
          end
          if (age < AW'(DEPTH)) age <= age + 1'b1;
        end
      end

      assign dout = d_q[DEPTH-1];
      assign vout = v_q[DEPTH-1];

      // R10/R8: nothing valid can emerge before DEPTH loads after reset
      a_r10_no_early_valid: assert property (@(posedge clk) disable iff (rst)
        (age < AW'(DEPTH)) |-> !vout);
    end
  endgenerate

endmodule

// File: rtl/cdot_cmul.sv
module cdot_cmul
  import cdot_pkg::*;
#(
  parameter int EW   = 8,
  parameter int RW   = 16,
  parameter int DROP = 0,
  parameter bit SAT  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [EW-1:0]        ar,
  input  logic [EW-1:0]        ai,
  input  logic [EW-1:0]        br,
  input  logic [EW-1:0]        bi,
  output logic signed [RW-1:0] pr,
  output logic signed [RW-1:0] pi
);

  logic signed [EW-1:0] sar, sai, sbr, sbi;
  wide_t raw_re, raw_im;   // exact conjugate product after floor shift

  assign sar = ar;
  assign sai = ai;
  assign sbr = br;
  assign sbi = bi;

  always_comb begin
    raw_re = conj_re(64'(sar), 64'(sai), 64'(sbr), 64'(sbi)) >>> DROP;
    raw_im = conj_im(64'(sar), 64'(sai), 64'(sbr), 64'(sbi)) >>> DROP;
    pr = RW'(fit(raw_re, RW, SAT));
    pi = RW'(fit(raw_im, RW, SAT));
  end

  // R3: real lanes give a zero imaginary product
  always @(posedge clk) begin
    if (!rst && sai == '0 && sbi == '0)
      a_r3_real_lane: assert (pi == '0);
  end

endmodule

// File: rtl/cdot_sum.sv
module cdot_sum
  import cdot_pkg::*;
#(
  parameter int N    = 4,
  parameter int RW   = 16,
  parameter bit SAT  = 1'b0,
  parameter bit TREE = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N*RW-1:0]      terms,
  output logic signed [RW-1:0] total
);

  localparam int    LV = $clog2(N);
  localparam int    P  = 1 << LV;
  localparam wide_t HI = (64'sd1 <<< (RW - 1)) - 64'sd1;

  generate
    if (TREE) begin : g_tree
      for (genvar l = 0; l <= LV; l++) begin : lvl
        localparam int WN = P >> l;
        logic [WN*RW-1:0] v;
        if (l == 0) begin : g_leaf
          assign v = (WN*RW)'(terms);   // unused leaves are zero
        end else begin : g_add
          for (genvar k = 0; k < WN; k++) begin : node
            logic signed [RW-1:0] lhs, rhs;
            assign lhs = lvl[l-1].v[(2*k)*RW +: RW];
            assign rhs = lvl[l-1].v[(2*k+1)*RW +: RW];
            assign v[k*RW +: RW] = RW'(fit(64'(lhs) + 64'(rhs), RW, SAT));
          end
        end
      end
      assign total = lvl[LV].v;
    end else begin : g_chain
      for (genvar i = 0; i < N; i++) begin : stg
        logic signed [RW-1:0] s;
        if (i == 0) begin : g_first
          assign s = terms[0 +: RW];
        end else begin : g_next
          logic signed [RW-1:0] t;
          assign t = terms[i*RW +: RW];
          assign s = RW'(fit(64'(stg[i-1].s) + 64'(t), RW, SAT));
        end
      end
      assign total = stg[N-1].s;
    end
  endgenerate

  // Exact reference sum and sign summary, used by the assertions below
  wide_t exact;
  logic  all_nonneg;
  always_comb begin
    exact      = '0;
    all_nonneg = 1'b1;
    for (int i = 0; i < N; i++) begin
      exact = exact + 64'($signed(terms[i*RW +: RW]));
      if (terms[i*RW + RW - 1]) all_nonneg = 1'b0;
    end
  end

  generate
    if (SAT) begin : g_sat_chk
      // R5: nonnegative terms saturate monotonically at the top of the range
      a_r5_sat_nonneg: assert property (@(posedge clk) disable iff (rst)
        all_nonneg |-> (64'(total) == ((exact > HI) ? HI : exact)));
    end else begin : g_wrap_chk
      // R4/R7: wrapped sums agree with the exact sum modulo 2^RW in any order
      a_r4_wrap_modular: assert property (@(posedge clk) disable iff (rst)
        total == exact[RW-1:0]);
    end
  endgenerate

endmodule

// File: rtl/cdot_unit.sv
module cdot_unit
  import cdot_pkg::*;
#(
  parameter int ELEM_W     = 8,
  parameter int LEN        = 4,
  parameter int RES_W      = 16,
  parameter int DROP_LSB   = 0,
  parameter bit TREE       = 1'b0,
  parameter bit SATURATE   = 1'b0,
  parameter int IN_STAGES  = 0,
  parameter int OUT_STAGES = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [LEN*ELEM_W-1:0] a_re,
  input  logic [LEN*ELEM_W-1:0] a_im,
  input  logic [LEN*ELEM_W-1:0] b_re,
  input  logic [LEN*ELEM_W-1:0] b_im,
  output logic                  out_valid,
  output logic [RES_W-1:0]      y_re,
  output logic [RES_W-1:0]      y_im
);

  localparam int VW = LEN * ELEM_W;
  localparam int IW = 4 * VW;
  localparam int OW = 2 * RES_W;

  // Input register stages
  logic [IW-1:0] in_q;
  logic          v_mid;
  logic [VW-1:0] ar_q, ai_q, br_q, bi_q;

  cdot_pipe #(.W(IW), .DEPTH(IN_STAGES)) u_in_pipe (
    .clk(clk), .rst(rst),
    .din({b_im, b_re, a_im, a_re}), .vin(in_valid),
    .dout(in_q), .vout(v_mid)
  );
  assign {bi_q, br_q, ai_q, ar_q} = in_q;

  // Lane conjugate multipliers
  logic [LEN*RES_W-1:0] prod_re, prod_im;
  generate
    for (genvar i = 0; i < LEN; i++) begin : lane
      logic signed [RES_W-1:0] pr, pi;
      cdot_cmul #(.EW(ELEM_W), .RW(RES_W), .DROP(DROP_LSB), .SAT(SATURATE)) u_mul (
        .clk(clk), .rst(rst),
        .ar(ar_q[i*ELEM_W +: ELEM_W]), .ai(ai_q[i*ELEM_W +: ELEM_W]),
        .br(br_q[i*ELEM_W +: ELEM_W]), .bi(bi_q[i*ELEM_W +: ELEM_W]),
        .pr(pr), .pi(pi)
      );
      assign prod_re[i*RES_W +: RES_W] = pr;
      assign prod_im[i*RES_W +: RES_W] = pi;
    end
  endgenerate

  // Reduction adders, one per component
  logic signed [RES_W-1:0] sum_re, sum_im;

  cdot_sum #(.N(LEN), .RW(RES_W), .SAT(SATURATE), .TREE(TREE)) u_sum_re (
    .clk(clk), .rst(rst), .terms(prod_re), .total(sum_re)
  );
  cdot_sum #(.N(LEN), .RW(RES_W), .SAT(SATURATE), .TREE(TREE)) u_sum_im (
    .clk(clk), .rst(rst), .terms(prod_im), .total(sum_im)
  );

  // Output register stages
  logic [OW-1:0] out_q;
  cdot_pipe #(.W(OW), .DEPTH(OUT_STAGES)) u_out_pipe (
    .clk(clk), .rst(rst),
    .din({sum_im, sum_re}), .vin(v_mid),
    .dout(out_q), .vout(out_valid)
  );
  assign {y_im, y_re} = out_q;

endmodule

// File: tb/cdot_unit_test.sv
module cdot_unit_test;

  localparam int NL = 4;
  localparam int NV = 6;

  // Rows: per lane (ar, ai, br, bi), lanes 0..3
  localparam logic signed [7:0] TV [NV][16] = '{
    '{8'sd1, 8'sd0, 8'sd5, 8'sd0,   8'sd2, 8'sd0, 8'sd6, 8'sd0,
      8'sd3, 8'sd0, 8'sd7, 8'sd0,   8'sd4, 8'sd0, 8'sd8, 8'sd0},
    '{8'sd1, 8'sd2, 8'sd3, 8'sd4,   8'sd0, 8'sd0, 8'sd0, 8'sd0,
      8'sd0, 8'sd0, 8'sd0, 8'sd0,   8'sd0, 8'sd0, 8'sd0, 8'sd0},
    '{-8'sd128, -8'sd128, -8'sd128, -8'sd128,  -8'sd128, -8'sd128, -8'sd128, -8'sd128,
      -8'sd128, -8'sd128, -8'sd128, -8'sd128,  -8'sd128, -8'sd128, -8'sd128, -8'sd128},
    '{8'sd100, 8'sd100, 8'sd100, 8'sd100,    8'sd100, 8'sd100, 8'sd100, 8'sd100,
      8'sd100, 8'sd100, -8'sd100, -8'sd100,  8'sd100, 8'sd100, -8'sd100, -8'sd100},
    '{8'sd7, -8'sd3, -8'sd5, 8'sd9,          -8'sd128, 8'sd127, 8'sd127, -8'sd128,
      8'sd0, 8'sd1, -8'sd1, 8'sd0,           8'sd50, -8'sd60, 8'sd70, -8'sd80},
    '{8'sd127, 8'sd127, 8'sd127, 8'sd127,    8'sd127, 8'sd127, 8'sd127, 8'sd127,
      8'sd127, 8'sd127, 8'sd127, 8'sd127,    8'sd127, 8'sd127, 8'sd127, 8'sd127}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [NL*8-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic        v_p, v_s, v_t, v_o;
  logic [15:0] re_p, im_p, re_s, im_s, re_t, im_t, re_o, im_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cdot_unit #(.ELEM_W(8), .LEN(NL), .RES_W(16), .DROP_LSB(0), .TREE(1'b0),
              .SATURATE(1'b0), .IN_STAGES(1), .OUT_STAGES(2)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(v_p), .y_re(re_p), .y_im(im_p));

  cdot_unit #(.ELEM_W(8), .LEN(NL), .RES_W(16), .DROP_LSB(0), .TREE(1'b1),
              .SATURATE(1'b1), .IN_STAGES(0), .OUT_STAGES(0)) uut_sat (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(v_s), .y_re(re_s), .y_im(im_s));

  cdot_unit #(.ELEM_W(8), .LEN(NL), .RES_W(16), .DROP_LSB(0), .TREE(1'b1),
              .SATURATE(1'b0), .IN_STAGES(0), .OUT_STAGES(0)) uut_tree (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(v_t), .y_re(re_t), .y_im(im_t));

  cdot_unit #(.ELEM_W(8), .LEN(1), .RES_W(16), .DROP_LSB(1), .TREE(1'b0),
              .SATURATE(1'b0), .IN_STAGES(0), .OUT_STAGES(0)) uut_one (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_re(a_re[7:0]), .a_im(a_im[7:0]), .b_re(b_re[7:0]), .b_im(b_im[7:0]),
    .out_valid(v_o), .y_re(re_o), .y_im(im_o));

  // ---------------- reference model ----------------
  function automatic longint lim16(longint v, bit sat);
    longint r;
    if (sat) begin
      r = (v > 32767) ? 32767 : ((v < -32768) ? -32768 : v);
    end else begin
      r = v & 64'hFFFF;
      if (r >= 32768) r = r - 65536;
    end
    return r;
  endfunction

  function automatic longint floor_half(longint v, int d);
    longint r = v;
    for (int k = 0; k < d; k++) begin
      if (r < 0 && (r % 2) != 0) r = (r - 1) / 2;
      else r = r / 2;
    end
    return r;
  endfunction

  task automatic model(input int row, input int n, input int d, input bit sat,
                       input bit tree, output longint xr, output longint xi);
    longint pr [NL];
    longint pq [NL];
    for (int i = 0; i < n; i++) begin
      longint ar = TV[row][4*i], ai = TV[row][4*i+1];
      longint br = TV[row][4*i+2], bi = TV[row][4*i+3];
      pr[i] = lim16(floor_half(br * ar - (-ai) * bi, d), sat);
      pq[i] = lim16(floor_half((-ai) * br + ar * bi, d), sat);
    end
    if (n == 1) begin
      xr = pr[0]; xi = pq[0];
    end else if (tree) begin
      xr = lim16(lim16(pr[0] + pr[1], sat) + lim16(pr[2] + pr[3], sat), sat);
      xi = lim16(lim16(pq[0] + pq[1], sat) + lim16(pq[2] + pq[3], sat), sat);
    end else begin
      xr = pr[0]; xi = pq[0];
      for (int i = 1; i < n; i++) begin
        xr = lim16(xr + pr[i], sat);
        xi = lim16(xi + pq[i], sat);
      end
    end
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint s16(logic [15:0] v);
    return longint'($signed(v));
  endfunction

  task automatic drive_row(input int row, input logic v);
    in_valid = v;
    for (int i = 0; i < NL; i++) begin
      a_re[i*8 +: 8] = TV[row][4*i];
      a_im[i*8 +: 8] = TV[row][4*i+1];
      b_re[i*8 +: 8] = TV[row][4*i+2];
      b_im[i*8 +: 8] = TV[row][4*i+3];
    end
  endtask

  task automatic drive_one(input int ar, input int ai, input int br, input int bi);
    a_re = '0; a_im = '0; b_re = '0; b_im = '0;
    a_re[7:0] = 8'(ar); a_im[7:0] = 8'(ai);
    b_re[7:0] = 8'(br); b_im[7:0] = 8'(bi);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(100000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    longint er, ei;

    // R10: reset state, valid data presented while in reset
    drive_row(0, 1'b1);
    repeat (3) @(negedge clk);
    chk("R10 reset out_valid", v_p, 0);
    chk("R10 reset y_re", s16(re_p), 0);
    chk("R10 reset y_im", s16(im_p), 0);
    rst = 1'b0;
    in_valid = 1'b0;

    // Table walk, one new row every cycle (R8 back-to-back)
    for (int k = 0; k < NV + 3; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        model(k - 3, NL, 0, 1'b0, 1'b0, er, ei);
        chk("R8 pipelined out_valid", v_p, 1);
        chk("R1 chain wrap y_re", s16(re_p), er);
        chk("R1 chain wrap y_im", s16(im_p), ei);
      end else begin
        chk("R8 latency not yet valid", v_p, 0);
      end
      if (k < NV) drive_row(k, 1'b1);
      else begin
        in_valid = 1'b0; a_re = '0; a_im = '0; b_re = '0; b_im = '0;
      end
      #1;
      if (k < NV) begin
        model(k, NL, 0, 1'b1, 1'b1, er, ei);
        chk("R6 tree sat y_re", s16(re_s), er);
        chk("R6 tree sat y_im", s16(im_s), ei);
        model(k, NL, 0, 1'b0, 1'b0, er, ei);   // chain order, wrap
        chk("R7 tree equals chain y_re", s16(re_t), er);
        chk("R7 tree equals chain y_im", s16(im_t), ei);
        chk("R8 zero latency valid", v_s, 1);
        model(k, 1, 1, 1'b0, 1'b0, er, ei);
        chk("R2 single lane y_re", s16(re_o), er);
        chk("R2 single lane y_im", s16(im_o), ei);
        if (k == 0) begin
          chk("R3 real inputs chain im", s16(im_t), 0);
          chk("R1 real dot value", s16(re_t), 70);
        end
        if (k == 1) begin
          chk("R1 conj re 1+2j,3+4j", s16(re_t), 11);
          chk("R1 conj im 1+2j,3+4j", s16(im_t), -2);
        end
        if (k == 2) begin
          chk("R5 product clamp high", s16(re_s), 32767);
          chk("R4 wrapped sum", s16(re_t), 0);
        end
        if (k == 3) begin
          chk("R6 partial sums clamp", s16(re_s), -1);
          chk("R4 wrap partial sums", s16(re_t), 0);
        end
      end
    end

    // R8: gap in valid gives no output at the same latency
    @(negedge clk);
    chk("R8 gap out_valid", v_p, 0);

    // R9: floor narrowing on the single-lane instance (DROP_LSB = 1)
    drive_one(1, 0, -3, 0);
    #1;
    chk("R9 floor of -3/2", s16(re_o), -2);
    drive_one(3, 0, 3, 0);
    #1;
    chk("R9 floor of 9/2", s16(re_o), 4);
    drive_one(0, -1, 0, 1);   // conj(-j)*(j) = -1 -> floor(-1/2) = -1
    #1;
    chk("R9 floor of -1/2", s16(re_o), -1);
    chk("R3 zero-imag product im", s16(im_o), 0);

    // R10: reset in mid-stream discards data in flight
    @(negedge clk);
    drive_row(5, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 mid reset out_valid", v_p, 0);
    chk("R10 mid reset y_re", s16(re_p), 0);
    repeat (2) @(negedge clk);
    chk("R10 flushed row stays invalid", v_p, 0);
    chk("R10 flushed y_im", s16(im_p), 0);

    summary();
    $finish;
  end

endmodule